// File: doc/BRIEF.md
# Seconds Clock with Alarm Compare

This block is the register-level core of a wall-clock timer. It holds a 32-bit count of whole seconds that moves forward by one on every cycle where a one-per-second strobe is high. Beside it sits a 32-bit alarm value. When the count reaches the alarm value and the alarm is armed, the block latches a sticky alarm flag and, if it is unmasked, drives an interrupt line.

Software reaches the block through a plain 32-bit register bus: a write strobe, an 8-bit byte offset, write data and a combinational read-data return. There are two bit-field registers, a mode register and a retained-settings register. Each has three addresses: one that writes the whole value, one that ORs in the ones written, and one that clears the ones written. A fixed identity register reports that the clock is fitted.

Top module: `rtc_core`

## Requirements
- R1: Offset 0x10 always reads 0x8000_0000 (bit 31 set means the clock is fitted), and writes to it change nothing.
- R2: The mode register is written whole at offset 0x00, ORed at 0x04 and cleared bit-for-bit at 0x08. Only bits 0 (alarm interrupt enable), 1 (millisecond interrupt enable), 2 (alarm flag) and 4 (watchdog enable) are stored, so an all-ones write reads back as 0x17.
- R3: The settings register is written whole at 0x60, ORed at 0x64 and cleared at 0x68. Only bits 1 (wake enable), 2 (alarm arm) and 7 (wake flag) are stored, so an all-ones write reads back as 0x86.
- R4: After reset every stored register reads zero and the interrupt output is low.
- R5: The seconds count at offset 0x30 rises by one on each cycle with the tick strobe high, and it wraps from 0xFFFF_FFFF to 0.
- R6: The seconds count and the alarm value (offset 0x40) can be written and read back. A write to the seconds count in a cycle with the tick high wins, and the tick is lost.
- R7: When the seconds count and the alarm value become equal while settings bit 2 is 1, mode bit 2 is set on the following clock edge. Settings bit 7 is set with it if settings bit 1 is 1. With settings bit 2 at 0, neither flag is set.
- R8: The interrupt output is high exactly while mode bits 0 and 2 are both 1. The millisecond enable sets no flag.
- R9: The alarm flag stays set after the count moves past the alarm value, and it falls only when software clears it through a register write, for example a 1 in bit 2 at offset 0x08.
- R10: Offsets with no register read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_in | input | 1 | One-per-second strobe, one cycle wide |
| irq_out | output | 1 | Alarm interrupt request |

## Verification
The assertions assume one bus write at most per cycle. They assume the address is stable while the strobe is high. They also assume the alarm flag rises only from a hardware match or a software write to the mode register. The stimulus drives every write and tick for exactly one cycle, at the falling edge. When it arms the alarm, the match lies at least one tick in the future, or the alarm is written to equal the count on purpose. No case depends on a software clear and a hardware match landing in the same cycle.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_MODE  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_IDENT = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_SECS  = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_ALARM = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_KEEP  = 8'h60;
    localparam logic [ADDR_W-1:0] ALIAS_SET_STEP = 8'h04;
    localparam logic [ADDR_W-1:0] ALIAS_CLR_STEP = 8'h08;

    localparam int MODE_IRQ_EN_BIT = 0;
    localparam int MODE_MS_EN_BIT  = 1;
    localparam int MODE_FLAG_BIT   = 2;
    localparam int MODE_WD_EN_BIT  = 4;

    localparam int KEEP_WAKE_EN_BIT = 1;
    localparam int KEEP_ARM_BIT     = 2;
    localparam int KEEP_WOKE_BIT    = 7;

    typedef enum logic [1:0] {
        ALIAS_NONE,
        ALIAS_WHOLE,
        ALIAS_OR,
        ALIAS_CLEAR
    } alias_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       data;
    } bus_wr_t;

    function automatic alias_e alias_of(input logic [ADDR_W-1:0] addr,
                                        input logic [ADDR_W-1:0] base);
        if (addr == base)                       return ALIAS_WHOLE;
        else if (addr == base + ALIAS_SET_STEP) return ALIAS_OR;
        else if (addr == base + ALIAS_CLR_STEP) return ALIAS_CLEAR;
        else                                    return ALIAS_NONE;
    endfunction

    function automatic logic [31:0] alias_apply(input alias_e kind,
                                                input logic [31:0] cur,
                                                input logic [31:0] wdata);
        case (kind)
            ALIAS_WHOLE: return wdata;
            ALIAS_OR:    return cur | wdata;
            ALIAS_CLEAR: return cur & ~wdata;
            default:     return cur;
        endcase
    endfunction

endpackage

// File: rtl/rtc_alias_reg.sv
module rtc_alias_reg
    import rtc_core_pkg::*;
#(
    parameter int                DATA_W = 32,
    parameter logic [ADDR_W-1:0] BASE   = '0,
    parameter logic [DATA_W-1:0] MASK   = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_wr_t           wr,
    input  logic [DATA_W-1:0] hw_set,
    output logic [DATA_W-1:0] q
);
    alias_e            kind;
    logic [31:0]       sw_next;
    logic [DATA_W-1:0] nxt;

    always_comb begin
        kind    = wr.en ? alias_of(wr.addr, BASE) : ALIAS_NONE;
        sw_next = alias_apply(kind, 32'(q), wr.data);
        // a hardware event in the same cycle as a software clear is kept
        nxt     = (sw_next[DATA_W-1:0] | hw_set) & MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              tick,
    output logic [DATA_W-1:0] secs
);
    always_ff @(posedge clk) begin
        if (rst)       secs <= '0;
        else if (load) secs <= load_val;
        else if (tick) secs <= secs + DATA_W'(1);
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] secs,
    input  logic [DATA_W-1:0] alarm,
    input  logic              armed,
    output logic              hit
);
    logic equal_now;
    logic equal_q;

    assign equal_now = (secs == alarm);
    assign hit       = armed && equal_now && !equal_q;

    always_ff @(posedge clk) begin
        if (rst) equal_q <= 1'b1;
        else     equal_q <= equal_now;
    end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_core_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_in,
    output logic              irq_out
);
    localparam logic [DATA_W-1:0] MODE_MASK =
        DATA_W'((1 << MODE_IRQ_EN_BIT) | (1 << MODE_MS_EN_BIT) |
                (1 << MODE_FLAG_BIT)   | (1 << MODE_WD_EN_BIT));
    localparam logic [DATA_W-1:0] KEEP_MASK =
        DATA_W'((1 << KEEP_WAKE_EN_BIT) | (1 << KEEP_ARM_BIT) |
                (1 << KEEP_WOKE_BIT));
    localparam logic [DATA_W-1:0] IDENT_VALUE = DATA_W'(1) << (DATA_W - 1);

    bus_wr_t           wr;
    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] keep_q;
    logic [DATA_W-1:0] sec_q;
    logic [DATA_W-1:0] alarm_q;
    logic [DATA_W-1:0] mode_hw;
    logic [DATA_W-1:0] keep_hw;
    logic              alarm_hit;

    always_comb begin
        wr.en   = bus_wr_en;
        wr.addr = bus_addr;
        wr.data = 32'(bus_wdata);
    end

    always_comb begin
        mode_hw = '0;
        keep_hw = '0;
        mode_hw[MODE_FLAG_BIT] = alarm_hit;
        keep_hw[KEEP_WOKE_BIT] = alarm_hit && keep_q[KEEP_WAKE_EN_BIT];
    end

    rtc_alias_reg #(.DATA_W(DATA_W), .BASE(OFF_MODE), .MASK(MODE_MASK)) mode_reg_i (
        .clk(clk), .rst(rst), .wr(wr), .hw_set(mode_hw), .q(mode_q)
    );

    rtc_alias_reg #(.DATA_W(DATA_W), .BASE(OFF_KEEP), .MASK(KEEP_MASK)) keep_reg_i (
        .clk(clk), .rst(rst), .wr(wr), .hw_set(keep_hw), .q(keep_q)
    );

    rtc_sec_counter #(.DATA_W(DATA_W)) sec_i (
        .clk(clk), .rst(rst),
        .load(bus_wr_en && bus_addr == OFF_SECS),
        .load_val(bus_wdata),
        .tick(tick_in),
        .secs(sec_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                                      alarm_q <= '0;
        else if (bus_wr_en && bus_addr == OFF_ALARM)  alarm_q <= bus_wdata;
    end

    rtc_alarm_cmp #(.DATA_W(DATA_W)) cmp_i (
        .clk(clk), .rst(rst),
        .secs(sec_q), .alarm(alarm_q),
        .armed(keep_q[KEEP_ARM_BIT]),
        .hit(alarm_hit)
    );

    assign irq_out = mode_q[MODE_IRQ_EN_BIT] && mode_q[MODE_FLAG_BIT];

    always_comb begin
        case (bus_addr)
            OFF_MODE:  bus_rdata = mode_q;
            OFF_IDENT: bus_rdata = IDENT_VALUE;
            OFF_SECS:  bus_rdata = sec_q;
            OFF_ALARM: bus_rdata = alarm_q;
            OFF_KEEP:  bus_rdata = keep_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
    import rtc_core_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tick_in,
    input logic              irq_out,
    input logic [DATA_W-1:0] sec_q,
    input logic [DATA_W-1:0] mode_q,
    input logic [DATA_W-1:0] keep_q
);
    a_r5_tick_adds_one: assert property (@(posedge clk) disable iff (rst)
        (tick_in && !(bus_wr_en && bus_addr == OFF_SECS))
        |=> sec_q == DATA_W'($past(sec_q) + DATA_W'(1)));

    a_r6_write_beats_tick: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr == OFF_SECS) |=> sec_q == $past(bus_wdata));

    a_r9_flag_falls_by_sw: assert property (@(posedge clk) disable iff (rst)
        $fell(mode_q[MODE_FLAG_BIT]) |->
        ($past(bus_wr_en) && ($past(bus_addr) == OFF_MODE ||
                              $past(bus_addr) == OFF_MODE + ALIAS_CLR_STEP)));

    a_r7_flag_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_q[MODE_FLAG_BIT]) |->
        ($past(keep_q[KEEP_ARM_BIT]) ||
         ($past(bus_wr_en) && ($past(bus_addr) == OFF_MODE ||
                               $past(bus_addr) == OFF_MODE + ALIAS_SET_STEP))));

    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (mode_q[MODE_FLAG_BIT] && mode_q[MODE_IRQ_EN_BIT]));

    a_r10_hole_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 8'h20) |-> bus_rdata == '0);
endmodule

bind rtc_core rtc_core_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_in(tick_in),
    .irq_out(irq_out), .sec_q(sec_q), .mode_q(mode_q), .keep_q(keep_q)
);

// File: tb/rtc_core_tb_top.sv
module rtc_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_in = 1'b0;
    logic        irq_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rtc_core dut_i (
        .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_in(tick_in),
        .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_in = 1'b1;
        repeat (n) @(negedge clk);
        tick_in = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); check("R4 mode", v, 0);
        rd(8'h60, v); check("R4 keep", v, 0);
        rd(8'h30, v); check("R4 secs", v, 0);
        rd(8'h40, v); check("R4 alarm", v, 0);
        check("R4 irq", {31'd0, irq_out}, 0);
        rd(8'h10, v); check("R1 ident", v, 32'h8000_0000);
        wr(8'h10, 32'h0);
        rd(8'h10, v); check("R1 ident after write", v, 32'h8000_0000);
    endtask

    task automatic t_mode_alias();
        logic [31:0] v;
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); check("R2 whole", v, 32'h17);
        wr(8'h08, 32'h3);         rd(8'h00, v); check("R2 clear", v, 32'h14);
        wr(8'h04, 32'h1);         rd(8'h00, v); check("R2 or", v, 32'h15);
        check("R8 irq from sw flag", {31'd0, irq_out}, 1);
        wr(8'h00, 32'h0);         rd(8'h00, v); check("R2 whole zero", v, 0);
    endtask

    task automatic t_keep_alias();
        logic [31:0] v;
        wr(8'h64, 32'hFF); rd(8'h60, v); check("R3 or", v, 32'h86);
        wr(8'h68, 32'h04); rd(8'h60, v); check("R3 clear", v, 32'h82);
        wr(8'h60, 32'h0);  rd(8'h60, v); check("R3 whole", v, 0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        wr(8'h30, 32'd100); ticks(3); rd(8'h30, v); check("R5 count", v, 32'd103);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = 8'h30; bus_wdata = 32'd5; tick_in = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; tick_in = 1'b0;
        rd(8'h30, v); check("R6 write beats tick", v, 32'd5);
        wr(8'h30, 32'hFFFF_FFFF); ticks(1); rd(8'h30, v); check("R5 wrap", v, 0);
        wr(8'h40, 32'h1234_5678); rd(8'h40, v); check("R6 alarm rw", v, 32'h1234_5678);
    endtask

    task automatic t_alarm();
        logic [31:0] v;
        wr(8'h40, 32'd10); wr(8'h30, 32'd8);
        wr(8'h64, 32'h04); wr(8'h04, 32'h1);
        ticks(1); idle(2);
        rd(8'h00, v); check("R7 no early flag", v & 32'h4, 0);
        ticks(1); idle(2);
        rd(8'h00, v); check("R7 flag set", v & 32'h4, 32'h4);
        check("R8 irq high", {31'd0, irq_out}, 1);
        rd(8'h60, v); check("R7 no wake flag", v & 32'h80, 0);
        ticks(2); idle(1);
        rd(8'h00, v); check("R9 sticky", v & 32'h4, 32'h4);
        wr(8'h08, 32'h4);
        rd(8'h00, v); check("R9 cleared", v, 32'h1);
        check("R8 irq low", {31'd0, irq_out}, 0);
    endtask

    task automatic t_wake();
        logic [31:0] v;
        wr(8'h30, 32'd19); wr(8'h40, 32'd20); wr(8'h64, 32'h06);
        ticks(1); idle(2);
        rd(8'h60, v); check("R7 wake flag", v, 32'h86);
        wr(8'h08, 32'h4); wr(8'h68, 32'h80);
    endtask

    task automatic t_disarmed();
        logic [31:0] v;
        wr(8'h68, 32'h04); wr(8'h30, 32'd29); wr(8'h40, 32'd30);
        ticks(1); idle(2);
        rd(8'h00, v); check("R7 disarmed no flag", v & 32'h4, 0);
        rd(8'h60, v); check("R7 disarmed no wake", v & 32'h80, 0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(8'h64, 32'h04); wr(8'h08, 32'h1); wr(8'h04, 32'h2);
        wr(8'h30, 32'd39); wr(8'h40, 32'd40);
        ticks(1); idle(2);
        rd(8'h00, v); check("R8 flag while masked", v, 32'h6);
        check("R8 masked irq low", {31'd0, irq_out}, 0);
        wr(8'h04, 32'h1);
        check("R8 unmask irq high", {31'd0, irq_out}, 1);
    endtask

    task automatic t_holes();
        logic [31:0] v;
        wr(8'h30, 32'd77);
        wr(8'h20, 32'hDEAD_BEEF); rd(8'h20, v); check("R10 hole reads zero", v, 0);
        wr(8'h34, 32'h1);         rd(8'h30, v); check("R10 secs untouched", v, 32'd77);
        rd(8'h00, v);             check("R10 mode untouched", v, 32'h7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mode_alias();
        t_keep_alias();
        t_count();
        t_alarm();
        t_wake();
        t_disarmed();
        t_mask();
        t_holes();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule